// File: doc/BRIEF.md
# Neighbour-Wired Lookup Cell

This block is a single tile of a fine-grained reconfigurable fabric built as a regular grid. Each tile touches four neighbours and has no routing wires of its own. Only the clock is shared across the grid. The tile takes one bit from each neighbour and one bit from its own state flop. Together these five bits index a 32-bit truth table. The selected table bit drives all four side outputs at once, either straight through or after being held in the flop.

Connectivity is set entirely by the table contents. A neighbour is effectively disconnected when the table gives the same result for both values of that neighbour's bit. A tile used as a wire is a table that copies one chosen input and ignores every other address bit. A neighbour only uses the tile's output if its own table depends on the facing input.

The table is written by holding a load strobe high with a new word on the configuration bus. A synchronous reset clears only the state flop. A mode pin selects whether the outputs show the flop or the combinational table result.

Top module: `nbr_lut_cell`

## Requirements
- R1: With `mode_reg` = 0, every side output equals table bit `addr` in the same cycle. `addr` is the 5-bit value {state, in_n, in_e, in_s, in_w}: the state bit is address bit 4, north is bit 3, east bit 2, south bit 1 and west bit 0.
- R2: With `mode_reg` = 1, every side output shows the state flop. At each rising edge out of reset, the flop takes table bit `addr`.
- R3: The state bit used in the address is always the flop value, in both modes. A table that ignores the neighbours and inverts the state (word 0x0000FFFF) makes the flop toggle on every edge.
- R4: `out_n`, `out_e`, `out_s` and `out_w` always carry the same bit.
- R5: When `cfg_load` is 1 at a rising edge, the table takes `cfg_word` at that edge. Before that edge the old contents still decide the outputs, and the flop captures from the old contents at the loading edge itself.
- R6: When `cfg_load` is 0 at an edge, the table is unchanged whatever `cfg_word` carries.
- R7: `rst` = 1 at a rising edge clears the flop to 0. In registered mode the outputs read 0 in the following cycle.
- R8: Reset does not alter the table contents.
- R9: A routing table copies a single neighbour to all outputs. Word 0xAAAAAAAA follows west, and word 0xFF00FF00 follows north.
- R10: When reset and load meet at one edge, the flop clears and the new word is stored, both at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Grid-wide clock |
| rst | input | 1 | Synchronous reset of the state flop, active high |
| cfg_load | input | 1 | Table write strobe |
| cfg_word | input | 32 | New table contents, bit i answers address i |
| mode_reg | input | 1 | 1 = registered output, 0 = combinational output |
| in_n | input | 1 | Bit from the north neighbour |
| in_e | input | 1 | Bit from the east neighbour |
| in_s | input | 1 | Bit from the south neighbour |
| in_w | input | 1 | Bit from the west neighbour |
| out_n | output | 1 | Result toward north |
| out_e | output | 1 | Result toward east |
| out_s | output | 1 | Result toward south |
| out_w | output | 1 | Result toward west |

## Verification
Two collisions matter. A table write can land on the same edge as a flop capture, and a table write can land on the same edge as a reset. The first case is provoked in registered mode by loading a word that disagrees with the old word at the current address. The flop must show the old table's answer, and the new word must act only from the next cycle. The second case asserts `rst` and `cfg_load` together. A behavioural model then expects a cleared flop and the new table at once, judged through the outputs in both modes over the following cycles.

// File: rtl/nbr_cell_pkg.sv
package nbr_cell_pkg;
  localparam int unsigned SIDE_COUNT = 4;
  localparam int unsigned ADDR_W     = SIDE_COUNT + 1;
  localparam int unsigned LUT_BITS   = 1 << ADDR_W;

  // index of each side inside the packed neighbour vector (north highest)
  localparam int unsigned SIDE_W = 0;
  localparam int unsigned SIDE_S = 1;
  localparam int unsigned SIDE_E = 2;
  localparam int unsigned SIDE_N = 3;

  typedef logic [LUT_BITS-1:0]   lut_word_t;
  typedef logic [ADDR_W-1:0]     lut_addr_t;
  typedef logic [SIDE_COUNT-1:0] side_vec_t;

  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } out_mode_e;

  // state bit on top, neighbours below in N,E,S,W order
  function automatic lut_addr_t pack_addr(input logic state_bit, input side_vec_t sides);
    return {state_bit, sides};
  endfunction
endpackage

// File: rtl/nbr_cfg_store.sv
module nbr_cfg_store #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             load,
  input  logic [WIDTH-1:0] word_in,
  output logic [WIDTH-1:0] word_q
);
  // table contents survive reset on purpose; only the strobe writes them
  always_ff @(posedge clk) begin
    if (load) begin
      word_q <= word_in;
    end
  end
endmodule

// File: rtl/nbr_lut_mux.sv
module nbr_lut_mux #(
  parameter int unsigned SEL_W = 5
) (
  input  logic [(1<<SEL_W)-1:0] table_in,
  input  logic [SEL_W-1:0]      sel,
  output logic                  bit_out
);
  localparam int unsigned LEAVES = 1 << SEL_W;
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  // heap-ordered 2:1 tree: node k has children 2k+1 (sel bit 0) and 2k+2
  logic [NODES-1:0] node;

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    assign node[LEAVES-1+j] = table_in[j];
  end

  for (genvar d = 0; d < SEL_W; d++) begin : g_level
    for (genvar p = 0; p < (1 << d); p++) begin : g_node
      localparam int unsigned K = (1 << d) - 1 + p;
      assign node[K] = sel[SEL_W-1-d] ? node[2*K+2] : node[2*K+1];
    end
  end

  assign bit_out = node[0];
endmodule

// File: rtl/nbr_state_ff.sv
module nbr_state_ff (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else begin
      q <= d;
    end
  end
endmodule

// File: rtl/nbr_out_select.sv
module nbr_out_select
  import nbr_cell_pkg::*;
#(
  parameter int unsigned FANOUT = 4
) (
  input  logic              mode_reg,
  input  logic              comb_bit,
  input  logic              reg_bit,
  output logic [FANOUT-1:0] fan
);
  logic      result;
  out_mode_e mode;

  assign mode   = out_mode_e'(mode_reg);
  assign result = (mode == OUT_REG) ? reg_bit : comb_bit;

  for (genvar i = 0; i < FANOUT; i++) begin : g_fan
    assign fan[i] = result;
  end
endmodule

// File: rtl/nbr_lut_cell.sv
module nbr_lut_cell
  import nbr_cell_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_load,
  input  logic [LUT_BITS-1:0] cfg_word,
  input  logic                mode_reg,
  input  logic                in_n,
  input  logic                in_e,
  input  logic                in_s,
  input  logic                in_w,
  output logic                out_n,
  output logic                out_e,
  output logic                out_s,
  output logic                out_w
);
  lut_word_t table_q;
  side_vec_t side_vec;
  lut_addr_t addr;
  logic      state_q;
  logic      lut_bit;
  side_vec_t fan;

  assign side_vec[SIDE_N] = in_n;
  assign side_vec[SIDE_E] = in_e;
  assign side_vec[SIDE_S] = in_s;
  assign side_vec[SIDE_W] = in_w;

  // the state flop, never the output pin, closes the feedback path
  assign addr = pack_addr(state_q, side_vec);

  nbr_cfg_store #(.WIDTH(LUT_BITS)) u_cfg (
    .clk     (clk),
    .load    (cfg_load),
    .word_in (cfg_word),
    .word_q  (table_q)
  );

  nbr_lut_mux #(.SEL_W(ADDR_W)) u_mux (
    .table_in (table_q),
    .sel      (addr),
    .bit_out  (lut_bit)
  );

  nbr_state_ff u_state (
    .clk (clk),
    .rst (rst),
    .d   (lut_bit),
    .q   (state_q)
  );

  nbr_out_select #(.FANOUT(SIDE_COUNT)) u_out (
    .mode_reg (mode_reg),
    .comb_bit (lut_bit),
    .reg_bit  (state_q),
    .fan      (fan)
  );

  assign out_n = fan[SIDE_N];
  assign out_e = fan[SIDE_E];
  assign out_s = fan[SIDE_S];
  assign out_w = fan[SIDE_W];
endmodule

// File: rtl/nbr_lut_cell_chk.sv
module nbr_lut_cell_chk
  import nbr_cell_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                cfg_load,
  input logic [LUT_BITS-1:0] cfg_word,
  input logic                mode_reg,
  input logic                in_n,
  input logic                in_e,
  input logic                in_s,
  input logic                in_w,
  input logic                out_n,
  input logic                out_e,
  input logic                out_s,
  input logic                out_w,
  input logic [LUT_BITS-1:0] table_q,
  input logic                state_q
);
  // R1
  comb_out_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_reg |-> out_n == table_q[{state_q, in_n, in_e, in_s, in_w}]);

  // R2
  reg_out_chk: assert property (@(posedge clk) disable iff (rst)
    mode_reg |-> out_n == state_q);

  // R2
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> state_q == $past(table_q[{state_q, in_n, in_e, in_s, in_w}]));

  // R4
  sides_equal_chk: assert property (@(posedge clk) disable iff (rst)
    (out_n == out_e) && (out_e == out_s) && (out_s == out_w));

  // R5
  load_apply_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> table_q == $past(cfg_word));

  // R6
  table_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> $stable(table_q));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !state_q);

  // R8
  reset_keep_chk: assert property (@(posedge clk)
    rst && !cfg_load |=> $stable(table_q));

  // R10
  reset_load_chk: assert property (@(posedge clk)
    rst && cfg_load |=> table_q == $past(cfg_word) && !state_q);
endmodule

bind nbr_lut_cell nbr_lut_cell_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_load (cfg_load),
  .cfg_word (cfg_word),
  .mode_reg (mode_reg),
  .in_n     (in_n),
  .in_e     (in_e),
  .in_s     (in_s),
  .in_w     (in_w),
  .out_n    (out_n),
  .out_e    (out_e),
  .out_s    (out_s),
  .out_w    (out_w),
  .table_q  (table_q),
  .state_q  (state_q)
);

// File: tb/nbr_lut_cell_tb.sv
module nbr_lut_cell_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic        cfg_load = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        mode_reg = 1'b0;
  logic        in_n = 1'b0, in_e = 1'b0, in_s = 1'b0, in_w = 1'b0;
  logic        out_n, out_e, out_s, out_w;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // behavioural reference state
  logic [31:0] m_table = '0;
  logic        m_state = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  always #10 clk = ~clk;  // 50 MHz

  nbr_lut_cell dut_i (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .mode_reg(mode_reg), .in_n(in_n), .in_e(in_e), .in_s(in_s), .in_w(in_w),
    .out_n(out_n), .out_e(out_e), .out_s(out_s), .out_w(out_w)
  );

  task automatic next_rand(output logic [31:0] v);
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    v = rng;
  endtask

  // one clock: drive after the falling edge, compare, then advance the model
  task automatic step(input bit r, input bit ld, input logic [31:0] w,
                      input bit md, input logic [3:0] sides, input bit chk,
                      input string tag);
    logic [4:0] a;
    logic       exp;
    logic [3:0] got;
    logic       nxt;
    @(negedge clk);
    rst = r; cfg_load = ld; cfg_word = w; mode_reg = md;
    {in_n, in_e, in_s, in_w} = sides;
    #5;
    a   = {m_state, sides};
    exp = md ? m_state : m_table[a];
    got = {out_n, out_e, out_s, out_w};
    if (chk) begin
      total++;
      if (got !== {4{exp}}) begin
        bad++;
        $display("FAIL %s: outputs=%b expected=%b", tag, got, {4{exp}});
      end
    end
    @(posedge clk);
    nxt = r ? 1'b0 : m_table[a];
    if (ld) m_table = w;
    m_state = nxt;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: outputs=stuck expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] v2;
    // initial reset with a defined table
    step(1, 1, 32'h0, 1, 4'h0, 0, "init");
    // R7 reset state in registered mode
    step(0, 0, 32'h0, 1, 4'h0, 1, "R7");
    // R5 write west router; this cycle still sees the old table
    step(0, 1, 32'hAAAA_AAAA, 0, 4'h1, 1, "R5");
    // R9 west follower over every neighbour pattern
    for (int i = 0; i < 16; i++) step(0, 0, 32'h0, 0, 4'(i), 1, "R9");
    step(0, 1, 32'hFF00_FF00, 0, 4'h0, 1, "R5");
    // R9 north follower
    for (int i = 0; i < 16; i++) step(0, 0, 32'h0, 0, 4'(15 - i), 1, "R9");
    // R1 address order under random tables and inputs
    for (int i = 0; i < 40; i++) begin
      next_rand(v); next_rand(v2);
      step(0, (i % 4) == 0, v, 0, v2[3:0], 1, "R1");
    end
    // R3 inverting feedback in combinational mode
    step(0, 1, 32'h0000_FFFF, 0, 4'h5, 1, "R3");
    for (int i = 0; i < 8; i++) step(0, 0, 32'h0, 0, 4'(i), 1, "R3");
    // R2 toggle in registered mode, then random tables
    for (int i = 0; i < 8; i++) step(0, 0, 32'h0, 1, 4'(i), 1, "R2");
    for (int i = 0; i < 30; i++) begin
      next_rand(v); next_rand(v2);
      step(0, (i % 5) == 0, v, 1, v2[7:4], 1, "R2");
    end
    // R5 load at a capture edge: old table decides the capture
    step(0, 1, 32'hFFFF_FFFF, 1, 4'h3, 1, "R5");
    step(0, 1, 32'h0000_0000, 1, 4'h3, 1, "R5");
    step(0, 0, 32'h0, 1, 4'h3, 1, "R5");
    step(0, 0, 32'h0, 0, 4'h3, 1, "R5");
    // R6 bus activity without the strobe
    step(0, 1, 32'h6996_9669, 0, 4'h0, 1, "R6");
    for (int i = 0; i < 16; i++) begin
      next_rand(v);
      step(0, 0, v, 0, 4'(i), 1, "R6");
    end
    // R4 all sides agree under mixed modes
    for (int i = 0; i < 20; i++) begin
      next_rand(v); next_rand(v2);
      step(0, v2[8], v, v2[9], v2[3:0], 1, "R4");
    end
    // R8 reset in combinational mode keeps the table
    step(0, 1, 32'hC3A5_5A3C, 0, 4'h9, 1, "R8");
    step(1, 0, 32'h0, 0, 4'h9, 1, "R8");
    for (int i = 0; i < 16; i++) step(0, 0, 32'h0, 0, 4'(i), 1, "R8");
    // R10 reset and load on the same edge
    step(0, 0, 32'h0, 1, 4'h7, 1, "R10");
    step(1, 1, 32'h5555_5555, 1, 4'h7, 1, "R10");
    step(0, 0, 32'h0, 1, 4'h2, 1, "R10");
    for (int i = 0; i < 16; i++) step(0, 0, 32'h0, 0, 4'(i), 1, "R10");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule